// File: doc/BRIEF.md
# Port Pin Resolver with Alternate-Function Ownership

This block is one 8-bit general-purpose I/O port. Software reaches it over a small byte-wide register bus. There is a data latch at address 0x3 and a direction register at address 0x7. For every pin the block works out three values: whether the pad driver is on, which value the pad drives, and what a read of the data register returns for that pin. The pads, the converter and the timers sit outside the block.

Two kinds of peripheral can claim pins. A converter channel-select code claims one of pins 0 to 6, where channel 8 maps to pin 0 and channel 14 maps to pin 6. A timer prescaler field claims a clock pin when the field holds the external-clock code: timer A owns pin 6 and timer B owns pin 4. A claimed pin never drives. For a claimed pin, the direction bit only decides whether the read returns the latch or zero.

Pin levels pass through a two-stage synchronizer before the read path uses them. A build parameter removes the top pin for the smaller package.

Top module: `gpio_altfn_port`

## Requirements
- R1: After reset the direction register holds 0x00 and every output enable is low.
- R2: A write to address 0x3 loads the data latch on that clock edge. Bit i of `pin_out` always equals latch bit i for a present pin. Reset leaves the latch contents unchanged.
- R3: A write to address 0x7 loads the direction register, and a read at 0x7 returns it unchanged. A read at any other address except 0x3 returns 0x00. Writes to those other addresses change neither register.
- R4: A pin that no peripheral claims has its output enable equal to its direction bit, where 1 means output.
- R5: For a pin that no peripheral claims, a read at 0x3 returns the latch bit when the direction bit is 1. When the direction bit is 0 it returns the pin level. A pin-level change shows up in reads two clock edges after it is sampled, and not after one.
- R6: A channel-select value of 8+i, for i from 0 to 6, claims pin i. A claimed pin has its output enable low. It reads 0 when its direction bit is 0 and reads the latch when its direction bit is 1. Values 0 to 7 and 15 to 31 claim no pin.
- R7: When timer A's prescaler field is 3'b111 it claims pin 6, and when timer B's field is 3'b111 it claims pin 4. A claimed clock pin has its output enable low whatever its direction bit. It reads 0 when its direction bit is 0 and reads the latch when its direction bit is 1. Any other field value leaves the pin unclaimed.
- R8: With `HAS_TOP_PIN` = 0, pin 7 always reads 0, and its output enable and drive value stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register address; also selects the read data |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | W | Write data |
| reg_rd_data | output | W | Read data for `reg_addr`, combinational |
| adc_chan_sel | input | CH_W | Converter channel-select code |
| tima_ps | input | PS_W | Timer A prescaler field |
| timb_ps | input | PS_W | Timer B prescaler field |
| pin_in | input | W | Pad input levels, asynchronous |
| pin_out | output | W | Pad drive values |
| pin_oe | output | W | Pad output enables |

## Verification
The bench aims at the channel-select edges 7, 8, 14 and 15. A decoder that is off by one would either claim a pin with no converter channel or leave pin 6 drivable while it is selected.

It sets a direction bit to output on a pin that a timer has claimed. A design that lets the direction bit win would drive against the external clock. The bench also reads claimed pins set as inputs, where a design that forgot ownership would return the live pin level instead of zero.

It checks that the latch survives a reset pulse and that a pin change appears after exactly two edges. It also runs a second instance with the top pin removed, where any leak would show as a driven or nonzero bit 7.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned DEF_CH_W = 5;
  localparam int unsigned DEF_PS_W = 3;

  // Per-pin resolved controls.
  typedef struct packed {
    logic oe;
    logic drv;
    logic rd;
  } pin_ctl_t;

  // True when the channel code selects this pin as a converter input.
  function automatic logic owns_adc(input int sel, input int pin,
                                    input int first_ch, input int n_pins);
    return (pin < n_pins) && (sel == first_ch + pin);
  endfunction

  // True when a timer prescaler field selects the external clock pin.
  function automatic logic owns_tmr(input int ps, input int ext_code,
                                    input int pin, input int clk_pin);
    return (pin == clk_pin) && (ps == ext_code);
  endfunction

  // Value returned by a data-register read for one pin.
  function automatic logic read_bit(input logic present, input logic dir,
                                    input logic claimed, input logic latch,
                                    input logic synced);
    if (!present)     return 1'b0;
    else if (dir)     return latch;
    else if (claimed) return 1'b0;
    else              return synced;
  endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int W         = 8,
  parameter int ADDR_W    = 4,
  parameter int DATA_ADDR = 3,
  parameter int DIR_ADDR  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      latch_q,
  output logic [W-1:0]      dir_q,
  output logic              data_hit,
  output logic              dir_hit
);

  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_ADDR);

  logic data_we;
  logic dir_we;

  assign data_hit = (addr == DATA_A);
  assign dir_hit  = (addr == DIR_A);
  assign data_we  = wr && data_hit;
  assign dir_we   = wr && dir_hit;

  // The data latch has no reset term, so reset leaves its contents alone.
  always_ff @(posedge clk) begin
    if (data_we) latch_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_we) dir_q <= wdata;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
  import gpio_port_pkg::*;
#(
  parameter int CH_W         = 5,
  parameter int PS_W         = 3,
  parameter int PIN_IDX      = 0,
  parameter int ADC_FIRST_CH = 8,
  parameter int ADC_PINS     = 7,
  parameter int TMRA_PIN     = 6,
  parameter int TMRB_PIN     = 4,
  parameter int PS_EXT       = 7,
  parameter bit PRESENT      = 1'b1
) (
  input  logic [CH_W-1:0] chan_sel,
  input  logic [PS_W-1:0] psa,
  input  logic [PS_W-1:0] psb,
  input  logic            dir,
  input  logic            latch,
  input  logic            synced,
  output pin_ctl_t        ctl,
  output logic            adc_own,
  output logic            tmr_own
);

  assign adc_own = owns_adc(int'(chan_sel), PIN_IDX, ADC_FIRST_CH, ADC_PINS);
  assign tmr_own = owns_tmr(int'(psa), PS_EXT, PIN_IDX, TMRA_PIN)
                || owns_tmr(int'(psb), PS_EXT, PIN_IDX, TMRB_PIN);

  always_comb begin
    ctl.oe  = PRESENT && dir && !adc_own && !tmr_own;
    ctl.drv = PRESENT && latch;
    ctl.rd  = read_bit(PRESENT, dir, adc_own || tmr_own, latch, synced);
  end

endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
  import gpio_port_pkg::*;
#(
  parameter int W            = 8,
  parameter int ADDR_W       = 4,
  parameter int DATA_ADDR    = 3,
  parameter int DIR_ADDR     = 7,
  parameter int CH_W         = DEF_CH_W,
  parameter int PS_W         = DEF_PS_W,
  parameter int ADC_FIRST_CH = 8,
  parameter int ADC_PINS     = 7,
  parameter int TMRA_PIN     = 6,
  parameter int TMRB_PIN     = 4,
  parameter int PS_EXT       = 7,
  parameter int SYNC_STAGES  = 2,
  parameter bit HAS_TOP_PIN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rd_data,
  input  logic [CH_W-1:0]   adc_chan_sel,
  input  logic [PS_W-1:0]   tima_ps,
  input  logic [PS_W-1:0]   timb_ps,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe
);

  logic [W-1:0] latch_q;
  logic [W-1:0] dir_q;
  logic         data_hit;
  logic         dir_hit;
  logic [W-1:0] pin_sync;
  logic [W-1:0] port_rd;
  logic [W-1:0] adc_claim;
  logic [W-1:0] tmr_claim;

  gpio_regfile #(
    .W(W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
    .wdata(reg_wdata), .latch_q(latch_q), .dir_q(dir_q),
    .data_hit(data_hit), .dir_hit(dir_hit)
  );

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam bit PRES = (i < W - 1) || HAS_TOP_PIN;
    pin_ctl_t c;
    gpio_pin_ctl #(
      .CH_W(CH_W), .PS_W(PS_W), .PIN_IDX(i), .ADC_FIRST_CH(ADC_FIRST_CH),
      .ADC_PINS(ADC_PINS), .TMRA_PIN(TMRA_PIN), .TMRB_PIN(TMRB_PIN),
      .PS_EXT(PS_EXT), .PRESENT(PRES)
    ) u_ctl (
      .chan_sel(adc_chan_sel), .psa(tima_ps), .psb(timb_ps),
      .dir(dir_q[i]), .latch(latch_q[i]), .synced(pin_sync[i]),
      .ctl(c), .adc_own(adc_claim[i]), .tmr_own(tmr_claim[i])
    );
    assign pin_oe[i]  = c.oe;
    assign pin_out[i] = c.drv;
    assign port_rd[i] = c.rd;
  end

  always_comb begin
    reg_rd_data = '0;
    if (data_hit)     reg_rd_data = port_rd;
    else if (dir_hit) reg_rd_data = dir_q;
  end

endmodule

// File: rtl/gpio_altfn_port_chk.sv
module gpio_altfn_port_chk #(
  parameter int W            = 8,
  parameter int ADDR_W       = 4,
  parameter int DATA_ADDR    = 3,
  parameter int DIR_ADDR     = 7,
  parameter int CH_W         = 5,
  parameter int PS_W         = 3,
  parameter int ADC_FIRST_CH = 8,
  parameter int ADC_PINS     = 7,
  parameter int TMRA_PIN     = 6,
  parameter int TMRB_PIN     = 4,
  parameter int PS_EXT       = 7,
  parameter bit HAS_TOP_PIN  = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      reg_rd_data,
  input logic [CH_W-1:0]   adc_chan_sel,
  input logic [PS_W-1:0]   tima_ps,
  input logic [PS_W-1:0]   timb_ps,
  input logic [W-1:0]      pin_out,
  input logic [W-1:0]      pin_oe,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      latch_q
);

  localparam logic [W-1:0] PMASK = HAS_TOP_PIN ? {W{1'b1}} : {1'b0, {(W-1){1'b1}}};
  localparam logic [ADDR_W-1:0] DA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] RA = ADDR_W'(DIR_ADDR);

  // R4
  oe_needs_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~dir_q) == '0);

  // R2
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == DA) |=> (pin_out == ($past(reg_wdata) & PMASK)));

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA) |=> (dir_q == $past(reg_wdata)));

  // R3
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == RA) |-> (reg_rd_data == dir_q));

  // R3
  other_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != RA && reg_addr != DA) |-> (reg_rd_data == '0));

  // R5
  out_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == DA) |-> ((reg_rd_data & dir_q) == (latch_q & dir_q & PMASK)));

  for (genvar i = 0; i < ADC_PINS; i++) begin : g_adc
    // R6
    adc_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adc_chan_sel == CH_W'(ADC_FIRST_CH + i)) |->
        (!pin_oe[i] && (reg_addr != DA || dir_q[i] || !reg_rd_data[i])));
  end

  // R7
  tmra_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tima_ps == PS_W'(PS_EXT)) |->
      (!pin_oe[TMRA_PIN] && (reg_addr != DA || dir_q[TMRA_PIN] || !reg_rd_data[TMRA_PIN])));

  // R7
  tmrb_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timb_ps == PS_W'(PS_EXT)) |->
      (!pin_oe[TMRB_PIN] && (reg_addr != DA || dir_q[TMRB_PIN] || !reg_rd_data[TMRB_PIN])));

  if (!HAS_TOP_PIN) begin : g_small
    // R8
    top_pin_absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_oe[W-1] && !pin_out[W-1] && (reg_addr != DA || !reg_rd_data[W-1]));
  end

endmodule

bind gpio_altfn_port gpio_altfn_port_chk #(
  .W(W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR),
  .CH_W(CH_W), .PS_W(PS_W), .ADC_FIRST_CH(ADC_FIRST_CH), .ADC_PINS(ADC_PINS),
  .TMRA_PIN(TMRA_PIN), .TMRB_PIN(TMRB_PIN), .PS_EXT(PS_EXT), .HAS_TOP_PIN(HAS_TOP_PIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rd_data(reg_rd_data), .adc_chan_sel(adc_chan_sel),
  .tima_ps(tima_ps), .timb_ps(timb_ps), .pin_out(pin_out), .pin_oe(pin_oe),
  .dir_q(dir_q), .latch_q(latch_q)
);

// File: tb/gpio_altfn_port_tb.sv
module gpio_altfn_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [4:0] adc_chan_sel = '0;
  logic [2:0] tima_ps = '0;
  logic [2:0] timb_ps = '0;
  logic [7:0] pin_in = '0;
  logic [7:0] rd_big, rd_small, out_big, out_small, oe_big, oe_small;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] m_latch = '0;
  logic [7:0] m_dir = '0;

  always #4 clk = ~clk;

  gpio_altfn_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd_data(rd_big), .adc_chan_sel(adc_chan_sel),
    .tima_ps(tima_ps), .timb_ps(timb_ps), .pin_in(pin_in),
    .pin_out(out_big), .pin_oe(oe_big)
  );

  gpio_altfn_port #(.HAS_TOP_PIN(1'b0)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd_data(rd_small), .adc_chan_sel(adc_chan_sel),
    .tima_ps(tima_ps), .timb_ps(timb_ps), .pin_in(pin_in),
    .pin_out(out_small), .pin_oe(oe_small)
  );

  function automatic logic claimed(input int i);
    return (i < 7 && int'(adc_chan_sel) == 8 + i)
        || (i == 6 && tima_ps == 3'b111) || (i == 4 && timb_ps == 3'b111);
  endfunction

  function automatic logic [7:0] pmask(input bit big);
    return big ? 8'hFF : 8'h7F;
  endfunction

  function automatic logic [7:0] exp_oe(input bit big);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m_dir[i] && !claimed(i);
    return r & pmask(big);
  endfunction

  function automatic logic [7:0] exp_rd(input bit big);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = m_dir[i] ? m_latch[i] : (claimed(i) ? 1'b0 : pin_in[i]);
    return r & pmask(big);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 4'h3) m_latch = d;
    if (a == 4'h7) m_dir = d;
  endtask

  // Call at a falling edge; read data is combinational.
  task automatic peek(input logic [3:0] a);
    reg_addr = a;
    #1;
  endtask

  task automatic check_all(input string tag);
    peek(4'h3);
    check({tag, " rd"}, rd_big, exp_rd(1'b1));
    check({tag, " rd small R8"}, rd_small, exp_rd(1'b0));
    check({tag, " oe"}, oe_big, exp_oe(1'b1));
    check({tag, " oe small R8"}, oe_small, exp_oe(1'b0));
    check("R2 drive", out_big, m_latch);
    check("R2 R8 drive small", out_small, m_latch & 8'h7F);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 oe", oe_big, 8'h00);
    peek(4'h7);
    check("R1 dir", rd_big, 8'h00);

    // R3: direction readback, other addresses
    wr_reg(4'h7, 8'hA5);
    @(negedge clk); peek(4'h7);
    check("R3 dir readback", rd_big, 8'hA5);
    wr_reg(4'h5, 8'hFF);
    @(negedge clk); peek(4'h5);
    check("R3 other read", rd_big, 8'h00);
    peek(4'h7);
    check("R3 dir untouched", rd_big, 8'hA5);

    // R4 R2: plain pins drive by direction bit
    wr_reg(4'h3, 8'h3C);
    @(negedge clk);
    check_all("R4 R5 plain");

    // R5: synchronizer latency of exactly two edges
    wr_reg(4'h7, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'h96; reg_addr = 4'h3;
    @(negedge clk); #1;
    check("R5 one edge old", rd_big, 8'h00);
    @(negedge clk); #1;
    check("R5 two edges new", rd_big, 8'h96);

    // R6: channel boundaries
    pin_in = 8'hFF;
    wr_reg(4'h3, 8'h00);
    wr_reg(4'h7, 8'h00);
    foreach (m_latch[k]) begin end
    adc_chan_sel = 5'd7;  @(negedge clk); @(negedge clk);
    check_all("R6 chan7");
    adc_chan_sel = 5'd8;  @(negedge clk);
    check_all("R6 chan8");
    adc_chan_sel = 5'd14; @(negedge clk);
    check_all("R6 chan14");
    adc_chan_sel = 5'd15; @(negedge clk);
    check_all("R6 chan15");
    wr_reg(4'h7, 8'hFF); wr_reg(4'h3, 8'h41);
    adc_chan_sel = 5'd14; @(negedge clk);
    check_all("R6 chan14 out");

    // R7: timer clock pins with direction bit set to output
    adc_chan_sel = 5'd0;
    tima_ps = 3'b111; timb_ps = 3'b111; @(negedge clk);
    check_all("R7 both ext dir1");
    wr_reg(4'h7, 8'h00);
    check_all("R7 both ext dir0");
    tima_ps = 3'b110; timb_ps = 3'b011; wr_reg(4'h7, 8'h50);
    check_all("R7 not ext");

    // R2: latch survives reset
    tima_ps = 3'b000; timb_ps = 3'b000;
    wr_reg(4'h3, 8'h5A);
    rst_n = 1'b0; m_dir = 8'h00;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe after reset", oe_big, 8'h00);
    wr_reg(4'h7, 8'hFF);
    peek(4'h3);
    check("R2 latch kept", rd_big, 8'h5A);
    check("R2 R8 latch kept small", rd_small, 8'h5A);

    // Random mix
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      adc_chan_sel = ($urandom % 2) ? 5'(8 + $urandom % 7) : 5'($urandom);
      tima_ps = ($urandom % 2) ? 3'b111 : 3'($urandom);
      timb_ps = ($urandom % 2) ? 3'b111 : 3'($urandom);
      pin_in = 8'($urandom);
      wr_reg(4'h7, 8'($urandom));
      wr_reg(4'h3, 8'($urandom));
      @(negedge clk);
      check_all("R4 R5 R6 R7 random");
    end

    finish_run();
  end

endmodule